// File: doc/BRIEF.md
# Radix-4 Butterfly with Shift-and-Add Twiddle Rotation

This block performs one radix-4 decimation-in-time butterfly on four complex fixed-point samples. It needs no hardware multiplier and no twiddle table. On a start pulse it captures the four samples, a twiddle index and a mode bit. Three iterative CORDIC rotators then turn legs 1 to 3 by the twiddle powers taken from the index. Each rotator uses only shifts, adds and a short table of elementary angles. The three rotated legs and the unrotated leg 0 are combined with the four radix-4 coefficient rows. Each result is divided by four, and a one-cycle valid flag marks it.

A mode bit makes the same hardware return the magnitude of leg 0. In that mode the first rotator runs in vectoring mode, so an FFT datapath can produce a magnitude spectrum from the butterfly it already has. Address generation and sample storage are left to the surrounding engine.

Top module: `r4cb_top`

## Requirements
- R1: While reset is asserted and after reset is released, and before any operation, `valid` is 0 and every output is 0.
- R2: A `start` sampled high while the block is idle begins an operation. `valid` is high for exactly one cycle, after the (ITER+1)th rising edge that follows the sampling edge. With the default ITER=16 that is the 17th edge.
- R3: With `mode`=0 (butterfly), leg 0 is used unrotated. Legs 1, 2 and 3 are multiplied by W^(m·k) for m = 1, 2, 3, where W = e^(−j2π/N), N = 2^N_LOG2, k = `tw_idx`, and the phase index (m·k) is reduced mod N.
- R4: With the rotated legs a, b, c, d, the unscaled outputs are y0 = a+b+c+d, y1 = a−jb−c+jd, y2 = a−b+c−d and y3 = a+jb−c−jd.
- R5: Each output is the result of R4 divided by 4. Each output part lies within 6 LSB of the exact real-valued result.
- R6: Twiddle angles in every quadrant are reached with the accuracy of R5. This includes the boundary indices k = 0, N/4, N/2 and N−1.
- R7: With `mode`=1 (magnitude), `y0_re` carries |x0| within 6 LSB, and `y0_im` and y1 to y3 are all 0. In this mode x1 to x3 and `tw_idx` have no effect.
- R8: A `start` that arrives while an operation is in flight is ignored. Only one `valid` pulse follows, and it carries the first operation's result.
- R9: The outputs hold their values between `valid` pulses, whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (honoured when idle) |
| mode | input | 1 | 0 = butterfly, 1 = magnitude of leg 0 |
| tw_idx | input | N_LOG2 | Twiddle index k |
| x0_re | input | W | Leg 0 real part |
| x0_im | input | W | Leg 0 imaginary part |
| x1_re | input | W | Leg 1 real part |
| x1_im | input | W | Leg 1 imaginary part |
| x2_re | input | W | Leg 2 real part |
| x2_im | input | W | Leg 2 imaginary part |
| x3_re | input | W | Leg 3 real part |
| x3_im | input | W | Leg 3 imaginary part |
| y0_re | output | W+1 | Output 0 real (magnitude in mode 1) |
| y0_im | output | W+1 | Output 0 imaginary |
| y1_re | output | W+1 | Output 1 real |
| y1_im | output | W+1 | Output 1 imaginary |
| y2_re | output | W+1 | Output 2 real |
| y2_im | output | W+1 | Output 2 imaginary |
| y3_re | output | W+1 | Output 3 real |
| y3_im | output | W+1 | Output 3 imaginary |
| valid | output | 1 | One-cycle result strobe |

## Verification
The residual-angle and residual-y assertions assume the default iteration count. They also assume that the angle after pre-rotation never leaves ±90°, which the quadrant step guarantees for every index. The output-hold and single-pulse assertions assume that `start`, `mode` and the samples matter only on the edge that accepts an operation. The bench keeps to this by holding `start` for one cycle between falling edges. It drives signed W-bit samples up to the full-scale extremes and applies indices across all four quadrants. It also raises a second `start` in mid-flight and changes the inputs between operations.

// File: rtl/r4cb_pkg.sv
package r4cb_pkg;
  // Angle word: one full turn equals 2**ANG_W
  localparam int ANG_W = 20;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_OUT} r4cb_state_e;

  // atan(2**-i) scaled to the angle word
  function automatic logic signed [ANG_W-1:0] atan_step(input int i);
    int v;
    case (i)
      0: v = 131072;  1: v = 77376;  2: v = 40884;  3: v = 20753;
      4: v = 10417;   5: v = 5213;   6: v = 2607;   7: v = 1304;
      8: v = 652;     9: v = 326;    10: v = 163;   11: v = 81;
      12: v = 41;     13: v = 20;    14: v = 10;    15: v = 5;
      default: v = 0;
    endcase
    return ANG_W'(v);
  endfunction
endpackage

// File: rtl/r4cb_ctrl.sv
module r4cb_ctrl import r4cb_pkg::*; #(
  parameter int ITER = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  output logic                        load,
  output logic                        step,
  output logic                        last,
  output logic                        emit,
  output logic [$clog2(ITER)-1:0]     iter
);
  localparam int CW = $clog2(ITER);

  r4cb_state_e   state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    case (state_q)
      ST_IDLE: if (start) begin
        state_d = ST_RUN;
        cnt_d   = '0;
      end
      ST_RUN: begin
        if (cnt_q == CW'(ITER-1)) state_d = ST_OUT;
        else                      cnt_d   = cnt_q + 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign load = (state_q == ST_IDLE) && start;
  assign step = (state_q == ST_RUN);
  assign last = (cnt_q == CW'(ITER-1));
  assign emit = (state_q == ST_OUT);
  assign iter = cnt_q;

  // R2
  run_to_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && last) |=> emit);

  // R8
  busy_no_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> !load);
endmodule

// File: rtl/r4cb_cordic.sv
module r4cb_cordic import r4cb_pkg::*; #(
  parameter int W    = 16,
  parameter int FRAC = 4,
  parameter int ITER = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          load,
  input  logic                          step,
  input  logic                          last,
  input  logic                          vec,
  input  logic [$clog2(ITER)-1:0]       iter,
  input  logic signed [W-1:0]           in_re,
  input  logic signed [W-1:0]           in_im,
  input  logic signed [ANG_W-1:0]       ang,
  output logic signed [W:0]             out_re,
  output logic signed [W:0]             out_im
);
  localparam int IW  = W + 2 + FRAC;
  localparam int OW  = W + 1;
  localparam int QTR = 1 << (ANG_W - 2);

  logic signed [IW-1:0]    x_q, y_q, x_d, y_d;
  logic signed [ANG_W-1:0] z_q, z_d;
  logic                    vec_q, vec_d;
  logic signed [IW-1:0]    ext_re, ext_im, xs, ys;
  logic                    ccw;

  function automatic logic signed [IW-1:0] gain_fix(input logic signed [IW-1:0] v);
    return (v >>> 1) + (v >>> 3) - (v >>> 6) - (v >>> 9) - (v >>> 12) + (v >>> 14);
  endfunction

  always_comb begin
    ext_re = {{2{in_re[W-1]}}, in_re, {FRAC{1'b0}}};
    ext_im = {{2{in_im[W-1]}}, in_im, {FRAC{1'b0}}};
    xs     = x_q >>> iter;
    ys     = y_q >>> iter;
    ccw    = vec_q ? (y_q < 0) : (z_q >= 0);
    x_d    = x_q;
    y_d    = y_q;
    z_d    = z_q;
    vec_d  = vec_q;
    if (load) begin
      vec_d = vec;
      z_d   = '0;
      if (vec) begin
        x_d = (ext_re < 0) ? -ext_re : ext_re;
        y_d = (ext_re < 0) ? -ext_im : ext_im;
      end else if (ang > QTR) begin
        x_d = -ext_im;
        y_d = ext_re;
        z_d = ang - ANG_W'(QTR);
      end else if (ang < -QTR) begin
        x_d = ext_im;
        y_d = -ext_re;
        z_d = ang + ANG_W'(QTR);
      end else begin
        x_d = ext_re;
        y_d = ext_im;
        z_d = ang;
      end
    end else if (step) begin
      if (ccw) begin
        x_d = x_q - ys;
        y_d = y_q + xs;
        z_d = z_q - atan_step(int'(iter));
      end else begin
        x_d = x_q + ys;
        y_d = y_q - xs;
        z_d = z_q + atan_step(int'(iter));
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q   <= '0;
      y_q   <= '0;
      z_q   <= '0;
      vec_q <= 1'b0;
    end else if (load || step) begin
      x_q   <= x_d;
      y_q   <= y_d;
      z_q   <= z_d;
      vec_q <= vec_d;
    end
  end

  assign out_re = OW'(gain_fix(x_q) >>> FRAC);
  assign out_im = OW'(gain_fix(y_q) >>> FRAC);

  // R6
  rot_resid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && last && !vec_q) |=> (z_q < 64 && z_q > -64));

  // R7
  vec_resid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && last && vec_q) |=> (y_q < 256 && y_q > -256 && x_q >= 0));
endmodule

// File: rtl/r4cb_comb.sv
module r4cb_comb #(
  parameter int OW = 17
) (
  input  logic signed [OW-1:0] a_re, a_im, b_re, b_im,
  input  logic signed [OW-1:0] c_re, c_im, d_re, d_im,
  output logic signed [OW-1:0] y0_re, y0_im, y1_re, y1_im,
  output logic signed [OW-1:0] y2_re, y2_im, y3_re, y3_im
);
  localparam int SW = OW + 2;

  function automatic logic signed [SW-1:0] sx(input logic signed [OW-1:0] v);
    return SW'(v);
  endfunction

  logic signed [SW-1:0] s0r, s0i, s1r, s1i, s2r, s2i, s3r, s3i;

  always_comb begin
    s0r = sx(a_re) + sx(b_re) + sx(c_re) + sx(d_re);
    s0i = sx(a_im) + sx(b_im) + sx(c_im) + sx(d_im);
    s1r = sx(a_re) + sx(b_im) - sx(c_re) - sx(d_im);
    s1i = sx(a_im) - sx(b_re) - sx(c_im) + sx(d_re);
    s2r = sx(a_re) - sx(b_re) + sx(c_re) - sx(d_re);
    s2i = sx(a_im) - sx(b_im) + sx(c_im) - sx(d_im);
    s3r = sx(a_re) - sx(b_im) - sx(c_re) + sx(d_im);
    s3i = sx(a_im) + sx(b_re) - sx(c_im) - sx(d_re);
  end

  assign y0_re = OW'(s0r >>> 2);
  assign y0_im = OW'(s0i >>> 2);
  assign y1_re = OW'(s1r >>> 2);
  assign y1_im = OW'(s1i >>> 2);
  assign y2_re = OW'(s2r >>> 2);
  assign y2_im = OW'(s2i >>> 2);
  assign y3_re = OW'(s3r >>> 2);
  assign y3_im = OW'(s3i >>> 2);
endmodule

// File: rtl/r4cb_top.sv
module r4cb_top import r4cb_pkg::*; #(
  parameter int W      = 16,
  parameter int N_LOG2 = 8,
  parameter int ITER   = 16,
  parameter int FRAC   = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                mode,
  input  logic [N_LOG2-1:0]   tw_idx,
  input  logic signed [W-1:0] x0_re,
  input  logic signed [W-1:0] x0_im,
  input  logic signed [W-1:0] x1_re,
  input  logic signed [W-1:0] x1_im,
  input  logic signed [W-1:0] x2_re,
  input  logic signed [W-1:0] x2_im,
  input  logic signed [W-1:0] x3_re,
  input  logic signed [W-1:0] x3_im,
  output logic signed [W:0]   y0_re,
  output logic signed [W:0]   y0_im,
  output logic signed [W:0]   y1_re,
  output logic signed [W:0]   y1_im,
  output logic signed [W:0]   y2_re,
  output logic signed [W:0]   y2_im,
  output logic signed [W:0]   y3_re,
  output logic signed [W:0]   y3_im,
  output logic                valid
);
  localparam int OW = W + 1;
  localparam int CW = $clog2(ITER);
  localparam int SH = ANG_W - N_LOG2;

  logic          load, step, last, emit;
  logic [CW-1:0] iter;

  r4cb_ctrl #(.ITER(ITER)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .load(load),
    .step(step), .last(last), .emit(emit), .iter(iter)
  );

  logic signed [W-1:0]  leg_re [1:3];
  logic signed [W-1:0]  leg_im [1:3];
  logic signed [OW-1:0] rot_re [1:3];
  logic signed [OW-1:0] rot_im [1:3];

  assign leg_re[1] = mode ? x0_re : x1_re;
  assign leg_im[1] = mode ? x0_im : x1_im;
  assign leg_re[2] = x2_re;
  assign leg_im[2] = x2_im;
  assign leg_re[3] = x3_re;
  assign leg_im[3] = x3_im;

  for (genvar m = 1; m < 4; m++) begin : g_leg
    logic [N_LOG2-1:0] ph_idx;
    logic [ANG_W-1:0]  ph_raw;
    logic signed [ANG_W-1:0] ph_ang;
    assign ph_idx = N_LOG2'(tw_idx * m);
    assign ph_raw = {ph_idx, {SH{1'b0}}};
    assign ph_ang = $signed(ANG_W'(0) - ph_raw);

    r4cb_cordic #(.W(W), .FRAC(FRAC), .ITER(ITER)) u_cordic (
      .clk(clk), .rst_n(rst_n), .load(load), .step(step), .last(last),
      .vec((m == 1) ? mode : 1'b0), .iter(iter),
      .in_re(leg_re[m]), .in_im(leg_im[m]), .ang(ph_ang),
      .out_re(rot_re[m]), .out_im(rot_im[m])
    );
  end

  logic signed [W-1:0]  x0r_q, x0i_q;
  logic                 mode_q, valid_q, valid_d;
  logic signed [OW-1:0] c_out [8];
  logic signed [OW-1:0] y_q [8];
  logic signed [OW-1:0] y_d [8];

  r4cb_comb #(.OW(OW)) u_comb (
    .a_re(OW'(x0r_q)), .a_im(OW'(x0i_q)),
    .b_re(rot_re[1]), .b_im(rot_im[1]),
    .c_re(rot_re[2]), .c_im(rot_im[2]),
    .d_re(rot_re[3]), .d_im(rot_im[3]),
    .y0_re(c_out[0]), .y0_im(c_out[1]), .y1_re(c_out[2]), .y1_im(c_out[3]),
    .y2_re(c_out[4]), .y2_im(c_out[5]), .y3_re(c_out[6]), .y3_im(c_out[7])
  );

  always_comb begin
    valid_d = emit;
    y_d     = y_q;
    if (emit) begin
      if (mode_q) begin
        for (int i = 0; i < 8; i++) y_d[i] = '0;
        y_d[0] = rot_re[1];
      end else begin
        y_d = c_out;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x0r_q   <= '0;
      x0i_q   <= '0;
      mode_q  <= 1'b0;
      valid_q <= 1'b0;
      for (int i = 0; i < 8; i++) y_q[i] <= '0;
    end else begin
      valid_q <= valid_d;
      if (load) begin
        x0r_q  <= x0_re;
        x0i_q  <= x0_im;
        mode_q <= mode;
      end
      if (emit) y_q <= y_d;
    end
  end

  assign valid = valid_q;
  assign y0_re = y_q[0];
  assign y0_im = y_q[1];
  assign y1_re = y_q[2];
  assign y1_im = y_q[3];
  assign y2_re = y_q[4];
  assign y2_im = y_q[5];
  assign y3_re = y_q[6];
  assign y3_im = y_q[7];

  // R2
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q);

  // R7
  mag_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && mode_q) |-> (y0_im == 0 && y1_re == 0 && y1_im == 0 &&
                             y2_re == 0 && y2_im == 0 && y3_re == 0 && y3_im == 0));

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !emit |=> ($stable(y0_re) && $stable(y0_im) && $stable(y1_re) && $stable(y1_im) &&
               $stable(y2_re) && $stable(y2_im) && $stable(y3_re) && $stable(y3_im)));
endmodule

// File: tb/r4cb_top_bench.sv
`timescale 1ns/1ps
module r4cb_top_bench;
  localparam int  W = 16, NL = 8, N = 256, ITER = 16, OW = 17, NV = 8;
  localparam real TOL = 6.0;
  localparam real PI  = 3.14159265358979;

  localparam int T_XR[NV][4] = '{
    '{1000, 3000, 5000, -7000}, '{12000, 20000, -15000, 7000},
    '{-8000, 30000, -32768, 10000}, '{5000, -20000, 18000, -3000},
    '{32767, 32767, 32767, 32767}, '{-32768, -32768, -32768, -32768},
    '{30000, 111, 333, 555}, '{-32768, 1234, -4321, 999}};
  localparam int T_XI[NV][4] = '{
    '{2000, -4000, 6000, 8000}, '{-3000, 5000, 9000, -25000},
    '{4000, -30000, 32767, 10000}, '{5000, 12000, -6000, 27000},
    '{32767, 32767, 32767, 32767}, '{-32768, -32768, -32768, -32768},
    '{-20000, 222, 444, 666}, '{0, -777, 888, 17}};
  localparam int T_K[NV]  = '{0, 64, 128, 37, 201, 255, 99, 5};
  localparam bit T_MD[NV] = '{0, 0, 0, 0, 0, 0, 1, 1};
  localparam string T_REQ[NV] = '{"R4", "R6", "R6", "R3", "R3", "R6", "R7", "R7"};

  logic clk, rst_n, start, mode, valid;
  logic [NL-1:0] tw_idx;
  logic signed [W-1:0]  x0_re, x0_im, x1_re, x1_im, x2_re, x2_im, x3_re, x3_im;
  logic signed [OW-1:0] y0_re, y0_im, y1_re, y1_im, y2_re, y2_im, y3_re, y3_im;

  r4cb_top #(.W(W), .N_LOG2(NL), .ITER(ITER)) u_r4cb_top (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .tw_idx(tw_idx),
    .x0_re(x0_re), .x0_im(x0_im), .x1_re(x1_re), .x1_im(x1_im),
    .x2_re(x2_re), .x2_im(x2_im), .x3_re(x3_re), .x3_im(x3_im),
    .y0_re(y0_re), .y0_im(y0_im), .y1_re(y1_re), .y1_im(y1_im),
    .y2_re(y2_re), .y2_im(y2_im), .y3_re(y3_re), .y3_im(y3_im), .valid(valid));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int act[8];
  always_comb begin
    act[0] = y0_re; act[1] = y0_im; act[2] = y1_re; act[3] = y1_im;
    act[4] = y2_re; act[5] = y2_im; act[6] = y3_re; act[7] = y3_im;
  end

  task automatic chk_eq(string req, string what, int a, int e);
    n_chk++;
    if (a != e) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, a, e);
    end
  endtask

  task automatic chk_near(string req, string what, int a, real e);
    n_chk++;
    if (real'(a) - e > TOL || e - real'(a) > TOL) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0.2f", req, what, a, e);
    end
  endtask

  // Reference: rotate legs by W^(m*k), combine, divide by 4 (magnitude in mode 1)
  function automatic void model(input int xr[4], input int xi[4], input int k,
                                input bit md, output real e[8]);
    real rr[4], ri[4];
    if (md) begin
      for (int i = 0; i < 8; i++) e[i] = 0.0;
      e[0] = $sqrt(real'(xr[0]) * xr[0] + real'(xi[0]) * xi[0]);
      return;
    end
    for (int m = 0; m < 4; m++) begin
      real ph;
      ph = -2.0 * PI * real'((m * k) % N) / real'(N);
      rr[m] = xr[m] * $cos(ph) - xi[m] * $sin(ph);
      ri[m] = xr[m] * $sin(ph) + xi[m] * $cos(ph);
    end
    e[0] = (rr[0] + rr[1] + rr[2] + rr[3]) / 4.0;
    e[1] = (ri[0] + ri[1] + ri[2] + ri[3]) / 4.0;
    e[2] = (rr[0] + ri[1] - rr[2] - ri[3]) / 4.0;
    e[3] = (ri[0] - rr[1] - ri[2] + rr[3]) / 4.0;
    e[4] = (rr[0] - rr[1] + rr[2] - rr[3]) / 4.0;
    e[5] = (ri[0] - ri[1] + ri[2] - ri[3]) / 4.0;
    e[6] = (rr[0] - ri[1] - rr[2] + ri[3]) / 4.0;
    e[7] = (ri[0] + rr[1] - ri[2] - rr[3]) / 4.0;
  endfunction

  task automatic drive(input int xr[4], input int xi[4], input int k, input bit md);
    x0_re = W'(xr[0]); x0_im = W'(xi[0]); x1_re = W'(xr[1]); x1_im = W'(xi[1]);
    x2_re = W'(xr[2]); x2_im = W'(xi[2]); x3_re = W'(xr[3]); x3_im = W'(xi[3]);
    tw_idx = NL'(k); mode = md;
  endtask

  // Called at a falling edge; returns at the falling edge after the sampling edge
  task automatic launch();
    start = 1'b1;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_check(input int xr[4], input int xi[4], input int k,
                           input bit md, input string req);
    real e[8];
    model(xr, xi, k, md, e);
    drive(xr, xi, k, md);
    launch();
    repeat (ITER) @(posedge clk);
    @(negedge clk);
    chk_eq("R2", "valid before latency", int'(valid), 0);
    @(posedge clk); @(negedge clk);
    chk_eq("R2", "valid at latency", int'(valid), 1);
    for (int i = 0; i < 8; i++) begin
      if (md && i > 0) chk_eq(req, $sformatf("mag mode zero out %0d", i), act[i], 0);
      else             chk_near(req, $sformatf("out %0d k=%0d", i, k), act[i], e[i]);
    end
    @(negedge clk);
    chk_eq("R2", "valid one cycle", int'(valid), 0);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int zr[4] = '{0, 0, 0, 0};
    rst_n = 1'b0; start = 1'b0;
    drive(zr, zr, 0, 1'b0);
    repeat (3) @(negedge clk);
    // R1: reset state
    chk_eq("R1", "valid in reset", int'(valid), 0);
    chk_eq("R1", "y0_re in reset", act[0], 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk_eq("R1", "valid after reset", int'(valid), 0);
    chk_eq("R1", "y3_im after reset", act[7], 0);

    // Table walk
    for (int v = 0; v < NV; v++) begin
      int xr[4], xi[4];
      xr = T_XR[v]; xi = T_XI[v];
      run_check(xr, xi, T_K[v], T_MD[v], T_REQ[v]);
    end

    // R5: equal legs at k=0 give y0 = x exactly scaled, others zero
    begin
      int xr[4] = '{4000, 4000, 4000, 4000};
      int xi[4] = '{-8000, -8000, -8000, -8000};
      run_check(xr, xi, 0, 1'b0, "R5");
    end
    // R6: k = N-1 with mixed-sign legs
    begin
      int xr[4] = '{-100, 25000, -25000, 9000};
      int xi[4] = '{300, 1000, -18000, -29000};
      run_check(xr, xi, N - 1, 1'b0, "R6");
    end
    // R7: magnitude of pure negative imaginary and of zero
    begin
      int xr[4] = '{0, 7, 7, 7};
      int xi[4] = '{-25000, 7, 7, 7};
      run_check(xr, xi, 13, 1'b1, "R7");
      xi[0] = 0;
      run_check(xr, xi, 200, 1'b1, "R7");
    end

    // R8: second start while busy is ignored
    begin
      int ar[4], ai[4], br[4], bi[4], first, pulses;
      real e[8];
      ar = T_XR[3]; ai = T_XI[3]; br = T_XR[0]; bi = T_XI[0];
      model(ar, ai, T_K[3], 1'b0, e);
      drive(ar, ai, T_K[3], 1'b0);
      launch();
      first = 0; pulses = 0;
      for (int c = 1; c <= 40; c++) begin
        if (c == 4) begin drive(br, bi, 9, 1'b0); start = 1'b1; end
        if (c == 5) start = 1'b0;
        @(posedge clk); @(negedge clk);
        if (valid) begin
          pulses++;
          if (first == 0) begin
            first = c;
            for (int i = 0; i < 8; i++) chk_near("R8", $sformatf("first op out %0d", i), act[i], e[i]);
          end
        end
      end
      chk_eq("R8", "valid pulse edge", first, ITER + 1);
      chk_eq("R8", "single valid pulse", pulses, 1);
    end

    // R9: outputs hold while inputs change without start
    begin
      int held[8], nr[4], ni[4];
      held = act;
      nr = T_XR[4]; ni = T_XI[5];
      for (int c = 0; c < 10; c++) begin
        drive(nr, ni, c * 17, c[0]);
        @(negedge clk);
      end
      for (int i = 0; i < 8; i++) chk_eq("R9", $sformatf("held out %0d", i), act[i], held[i]);
      chk_eq("R9", "no valid without start", int'(valid), 0);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule